// File: doc/BRIEF.md
# Three-Phase Complementary PWM Generator

This block drives a three-phase inverter bridge. A 16-bit carrier counter runs in triangle fashion, from zero up to a programmed top value and back down. Each phase compares the carrier against its own duty value and produces a raw level. That level is split into a high-side output and a low-side output, and a programmable guard interval is inserted between the two sides at every switching edge. A duty value of zero keeps the high side on for the whole carrier cycle. A duty value at or above the top value keeps it off for the whole cycle.

Software writes the duty values into holding registers. Each value reaches the comparator only at a carrier turning point, so a write never cuts a pulse short in the middle of a cycle. The turning points also produce interrupt pulses, and a thinning count can pass only every (N+1)-th one. A converter start pulse follows each top turning point after a programmed number of cycles. An active-low fault input latches a shutdown that withdraws every output enable. Software can release the shutdown only after the fault input has returned high.

Configuration uses a single-cycle write strobe with a 3-bit register select and a 16-bit data word.

Top module: `tri_pwm_gen`

## Requirements
- R1: While run (control bit 0) is set and the top value (select 0) is nonzero, `carrier_cnt` changes by exactly one per clock. It counts up to the top value, then down to 0, then up again, and `carrier_up` is 1 while counting up. While run is clear, the carrier is held at 0 with `carrier_up` = 1.
- R2: Each phase's raw level is 1 in a carrier cycle where the count is at or above its active duty value, and that value is below the top value. Duty registers sit at selects 1, 2 and 3 for phases 0, 1 and 2. High-side outputs are `pwm_out[2:0]` and low-side outputs are `pwm_out[5:3]`, with bit i+3 paired to bit i.
- R3: A side turns on only after the raw level has stayed at that side's state for the guard count (select 4) of clocks. The two outputs of a phase are never 1 together, and a raw run no longer than the guard count produces nothing on that side.
- R4: Duty 0 keeps the high side on for the full carrier cycle. A duty at or above the top value keeps the low side on for the full cycle.
- R5: A duty write reaches the comparator at the next top or bottom turning point, or at once while run is clear.
- R6: A top turning point is the cycle in which the count equals the top value while counting up. A bottom turning point is the cycle in which the count is 0 while counting down. `irq_crest` and `irq_trough` are one-cycle pulses in the clock after a turning point of their kind. With thinning count N (select 5), exactly one in every N+1 turning points of each kind raises a pulse.
- R7: `adc_trig` pulses once, D+2 clocks after each top turning point cycle, where D is the delay register (select 6).
- R8: With level mode (control bit 1) set, a low `emerg_n` sets the shutdown within three clocks. During shutdown `pwm_oe` and `pwm_out` are all 0.
- R9: With level mode clear, a falling edge on `emerg_n` sets the shutdown. The shutdown stays set after the input returns high. Writing control bit 2 as 1 clears it only while the synchronised input is high.
- R10: After reset all outputs are 0 except `pwm_oe`, which is all ones, and `carrier_up`, which is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 16 | Register write data |
| emerg_n | input | 1 | Active-low fault input |
| pwm_out | output | 6 | High-side [2:0] and low-side [5:3] drive levels |
| pwm_oe | output | 6 | Output enables, 0 means high impedance |
| irq_crest | output | 1 | Top turning point interrupt pulse |
| irq_trough | output | 1 | Bottom turning point interrupt pulse |
| adc_trig | output | 1 | Delayed converter start pulse |
| carrier_cnt | output | 16 | Carrier counter value |
| carrier_up | output | 1 | Carrier direction, 1 while counting up |

## Verification
The assertions check every cycle that the carrier steps by one and that paired outputs never overlap. They also check that a low fault input in level mode trips the shutdown, that the shutdown holds while the input is low, that the enables drop during shutdown, and that each interrupt pulse arrives in the correct carrier direction. Only the bench's scenarios can measure whole-cycle quantities: per-side on-time against duty and guard count, exact interrupt thinning, converter trigger latency, the deferred duty transfer, and refusal of a clear while the fault is still present.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
   // register selects on the write strobe bus
   typedef enum logic [2:0] {
      REG_PERIOD = 3'd0,
      REG_DUTY_A = 3'd1,
      REG_DUTY_B = 3'd2,
      REG_DUTY_C = 3'd3,
      REG_DEAD   = 3'd4,
      REG_SKIP   = 3'd5,
      REG_ADC    = 3'd6,
      REG_CTRL   = 3'd7
   } reg_sel_e;

   // control word bit positions
   localparam int CTRL_RUN   = 0;
   localparam int CTRL_LEVEL = 1;
   localparam int CTRL_CLEAR = 2;
endpackage

// File: rtl/tri_pwm_carrier.sv
module tri_pwm_carrier #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] period,
   output logic [CNT_W-1:0] cnt,
   output logic             up,
   output logic             crest,
   output logic             trough
);
   logic active;
   assign active = run && (period != '0);
   assign crest  = active && up && (cnt >= period);
   assign trough = active && !up && (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (!active) begin
         cnt <= '0;
         up  <= 1'b1;
      end else if (up) begin
         if (cnt >= period) begin
            up  <= 1'b0;
            cnt <= cnt - 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end else begin
         if (cnt == '0) begin
            up  <= 1'b1;
            cnt <= cnt + 1'b1;
         end else begin
            cnt <= cnt - 1'b1;
         end
      end
   end
endmodule

// File: rtl/tri_pwm_deadband.sv
module tri_pwm_deadband #(
   parameter int DT_W    = 8,
   parameter bit OUT_REG = 1'b0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            raw,
   input  logic [DT_W-1:0] guard,
   output logic            hi_side,
   output logic            lo_side
);
   logic            level_q;
   logic [DT_W-1:0] age_q;
   logic            settled;
   logic            hi_w;
   logic            lo_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= 1'b0;
         age_q   <= '0;
      end else if (raw != level_q) begin
         level_q <= raw;
         age_q   <= '0;
      end else if (age_q < guard) begin
         age_q <= age_q + 1'b1;
      end
   end

   assign settled = (age_q >= guard);
   assign hi_w    = level_q && settled;
   assign lo_w    = !level_q && settled;

   generate
      if (OUT_REG) begin : g_reg
         logic hi_q, lo_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               hi_q <= 1'b0;
               lo_q <= 1'b0;
            end else begin
               hi_q <= hi_w;
               lo_q <= lo_w;
            end
         end
         assign hi_side = hi_q;
         assign lo_side = lo_q;
      end else begin : g_comb
         assign hi_side = hi_w;
         assign lo_side = lo_w;
      end
   endgenerate
endmodule

// File: rtl/tri_pwm_thin.sv
module tri_pwm_thin #(
   parameter int SKIP_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              evt,
   input  logic [SKIP_W-1:0] skip,
   output logic              pulse
);
   logic [SKIP_W-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seen_q <= '0;
         pulse  <= 1'b0;
      end else if (clr) begin
         seen_q <= '0;
         pulse  <= 1'b0;
      end else if (evt) begin
         pulse  <= (seen_q == skip);
         seen_q <= (seen_q == skip) ? '0 : seen_q + 1'b1;
      end else begin
         pulse <= 1'b0;
      end
   end
endmodule

// File: rtl/tri_pwm_estop.sv
module tri_pwm_estop #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   input  logic level_mode,
   input  logic clr_req,
   output logic shut,
   output logic pin_sync
);
   logic [SYNC_STAGES-1:0] chain_q;
   logic                   prev_q;
   logic                   trip;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[SYNC_STAGES-2:0], pin_n};
         prev_q  <= chain_q[SYNC_STAGES-1];
      end
   end

   assign pin_sync = chain_q[SYNC_STAGES-1];
   assign trip     = level_mode ? !pin_sync : (prev_q && !pin_sync);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 shut <= 1'b0;
      else if (trip)              shut <= 1'b1;
      else if (clr_req && pin_sync) shut <= 1'b0;
   end
endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen
   import tri_pwm_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int PHASES      = 3,
   parameter int DT_W        = 8,
   parameter int SKIP_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int DEF_PERIOD  = 1000,
   parameter bit DB_OUT_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [2:0]          wr_addr,
   input  logic [CNT_W-1:0]    wr_data,
   input  logic                emerg_n,
   output logic [2*PHASES-1:0] pwm_out,
   output logic [2*PHASES-1:0] pwm_oe,
   output logic                irq_crest,
   output logic                irq_trough,
   output logic                adc_trig,
   output logic [CNT_W-1:0]    carrier_cnt,
   output logic                carrier_up
);
   localparam int OUT_W = 2 * PHASES;

   generate
      if (CNT_W < 4)                   begin : g_bad_cnt   $error("CNT_W too small"); end
      if (PHASES < 1 || PHASES > 3)    begin : g_bad_ph    $error("PHASES must be 1..3"); end
      if (DT_W < 1 || DT_W > CNT_W)    begin : g_bad_dt    $error("DT_W out of range"); end
      if (SKIP_W < 1 || SKIP_W > CNT_W) begin : g_bad_skip $error("SKIP_W out of range"); end
      if (SYNC_STAGES < 2)             begin : g_bad_sync  $error("SYNC_STAGES below 2"); end
   endgenerate

   logic [CNT_W-1:0]  period_q;
   logic [DT_W-1:0]   dead_q;
   logic [SKIP_W-1:0] skip_q;
   logic [CNT_W-1:0]  adc_dly_q;
   logic              run_q;
   logic              level_q;
   reg_sel_e          sel;
   logic              crest_w, trough_w;
   logic              shut_w, pin_sync_w, clr_req;
   logic [PHASES-1:0] pos_w, neg_w;

   assign sel     = reg_sel_e'(wr_addr);
   assign clr_req = wr_en && (sel == REG_CTRL) && wr_data[CTRL_CLEAR];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         period_q  <= CNT_W'(DEF_PERIOD);
         dead_q    <= '0;
         skip_q    <= '0;
         adc_dly_q <= '0;
         run_q     <= 1'b0;
         level_q   <= 1'b0;
      end else if (wr_en) begin
         case (sel)
            REG_PERIOD: period_q  <= wr_data;
            REG_DEAD:   dead_q    <= wr_data[DT_W-1:0];
            REG_SKIP:   skip_q    <= wr_data[SKIP_W-1:0];
            REG_ADC:    adc_dly_q <= wr_data;
            REG_CTRL: begin
               run_q   <= wr_data[CTRL_RUN];
               level_q <= wr_data[CTRL_LEVEL];
            end
            default: ;
         endcase
      end
   end

   tri_pwm_carrier #(.CNT_W(CNT_W)) carrier_i (
      .clk(clk), .rst_n(rst_n), .run(run_q), .period(period_q),
      .cnt(carrier_cnt), .up(carrier_up), .crest(crest_w), .trough(trough_w)
   );

   // per-phase duty holding, compare and guard interval
   for (genvar g = 0; g < PHASES; g++) begin : g_phase
      localparam logic [2:0] MY_SEL = 3'(int'(REG_DUTY_A) + g);
      logic [CNT_W-1:0] hold_q, act_q;
      logic             raw_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hold_q <= '0;
            act_q  <= '0;
            raw_q  <= 1'b0;
         end else begin
            if (wr_en && wr_addr == MY_SEL) hold_q <= wr_data;
            if (!run_q || crest_w || trough_w) act_q <= hold_q;
            raw_q <= run_q && (act_q < period_q) && (carrier_cnt >= act_q);
         end
      end

      tri_pwm_deadband #(.DT_W(DT_W), .OUT_REG(DB_OUT_REG)) band_i (
         .clk(clk), .rst_n(rst_n), .raw(raw_q), .guard(dead_q),
         .hi_side(pos_w[g]), .lo_side(neg_w[g])
      );
   end

   // turning point interrupt thinning, index 0 top, 1 bottom
   logic [1:0] evt_w, irq_w;
   logic       thin_clr;
   assign evt_w    = {trough_w, crest_w};
   assign thin_clr = !run_q || (wr_en && sel == REG_SKIP);

   for (genvar k = 0; k < 2; k++) begin : g_thin
      tri_pwm_thin #(.SKIP_W(SKIP_W)) thin_i (
         .clk(clk), .rst_n(rst_n), .clr(thin_clr), .evt(evt_w[k]),
         .skip(skip_q), .pulse(irq_w[k])
      );
   end
   assign irq_crest  = irq_w[0];
   assign irq_trough = irq_w[1];

   // converter start, delayed from the top turning point
   logic             armed_q;
   logic [CNT_W-1:0] wait_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q  <= 1'b0;
         wait_q   <= '0;
         adc_trig <= 1'b0;
      end else begin
         adc_trig <= 1'b0;
         if (crest_w) begin
            armed_q <= 1'b1;
            wait_q  <= '0;
         end else if (armed_q) begin
            if (wait_q == adc_dly_q) begin
               adc_trig <= 1'b1;
               armed_q  <= 1'b0;
            end else begin
               wait_q <= wait_q + 1'b1;
            end
         end
      end
   end

   tri_pwm_estop #(.SYNC_STAGES(SYNC_STAGES)) estop_i (
      .clk(clk), .rst_n(rst_n), .pin_n(emerg_n), .level_mode(level_q),
      .clr_req(clr_req), .shut(shut_w), .pin_sync(pin_sync_w)
   );

   assign pwm_oe  = {OUT_W{~shut_w}};
   assign pwm_out = (shut_w || !run_q) ? '0 : {neg_w, pos_w};
endmodule

// File: rtl/tri_pwm_gen_chk.sv
module tri_pwm_gen_chk #(
   parameter int CNT_W  = 16,
   parameter int PHASES = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                run,
   input logic [CNT_W-1:0]    period,
   input logic [CNT_W-1:0]    cnt,
   input logic                up,
   input logic [2*PHASES-1:0] pwm_out,
   input logic [2*PHASES-1:0] pwm_oe,
   input logic                irq_crest,
   input logic                irq_trough,
   input logic                shut,
   input logic                level_mode,
   input logic                pin_sync
);
   // R1
   carrier_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && period != '0) |=> (!run || period == '0 ||
         cnt == $past(cnt) + 1'b1 || cnt == $past(cnt) - 1'b1));

   // R3
   no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_out[PHASES-1:0] & pwm_out[2*PHASES-1:PHASES]) == '0);

   // R6
   crest_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_crest && run) |-> !up);

   // R6
   trough_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_trough && run) |-> up);

   // R6
   irq_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irq_crest, irq_trough}));

   // R8
   level_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (level_mode && !pin_sync) |=> shut);

   // R8
   hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
      shut |-> (pwm_oe == '0 && pwm_out == '0));

   // R9
   shut_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (shut && !pin_sync) |=> shut);
endmodule

bind tri_pwm_gen tri_pwm_gen_chk #(.CNT_W(CNT_W), .PHASES(PHASES)) chk_i (
   .clk(clk), .rst_n(rst_n), .run(run_q), .period(period_q),
   .cnt(carrier_cnt), .up(carrier_up), .pwm_out(pwm_out), .pwm_oe(pwm_oe),
   .irq_crest(irq_crest), .irq_trough(irq_trough), .shut(shut_w),
   .level_mode(level_q), .pin_sync(pin_sync_w)
);

// File: tb/tri_pwm_gen_tb_top.sv
module tri_pwm_gen_tb_top;
   import tri_pwm_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        emerg_n = 1'b1;
   logic [5:0]  pwm_out, pwm_oe;
   logic        irq_crest, irq_trough, adc_trig;
   logic [15:0] carrier_cnt;
   logic        carrier_up;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;

   tri_pwm_gen dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .emerg_n(emerg_n), .pwm_out(pwm_out),
      .pwm_oe(pwm_oe), .irq_crest(irq_crest), .irq_trough(irq_trough),
      .adc_trig(adc_trig), .carrier_cnt(carrier_cnt), .carrier_up(carrier_up)
   );

   task automatic check(string req, int act, int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_rng(string req, int act, int lo, int hi);
      n_tests++;
      if (act < lo || act > hi) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
      end
   endtask

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [2:0] a, int d);
      @(negedge clk);
      wr_en   = 1'b1;
      wr_addr = a;
      wr_data = 16'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // raw high cycles in one carrier cycle of length 2P
   function automatic int raw_high(int p, int d);
      if (d == 0)  return 2 * p;
      if (d >= p)  return 0;
      return 2 * p - 2 * d + 1;
   endfunction

   function automatic int side_on(int len, int total, int dt);
      if (len == total) return total;
      return (len > dt) ? len - dt : 0;
   endfunction

   task automatic run_cfg(int p, int dt, int d0, int d1, int d2, int s, int dl);
      int duty[3];
      int pc[3];
      int nc[3];
      int overlap, car_err, pos_err, adc_err, adc_seen, ncrest, ntrough, since;
      int prev;
      duty[0] = d0; duty[1] = d1; duty[2] = d2;
      wr(REG_CTRL, 0);
      wr(REG_PERIOD, p);
      wr(REG_DEAD, dt);
      wr(REG_DUTY_A, d0);
      wr(REG_DUTY_B, d1);
      wr(REG_DUTY_C, d2);
      wr(REG_SKIP, s);
      wr(REG_ADC, dl);
      wr(REG_CTRL, 1);
      tick(4 * p + 2 * dt + 20);
      overlap = 0;
      for (int i = 0; i < 3; i++) begin pc[i] = 0; nc[i] = 0; end
      for (int c = 0; c < 2 * p; c++) begin
         @(negedge clk);
         for (int i = 0; i < 3; i++) begin
            pc[i] += int'(pwm_out[i]);
            nc[i] += int'(pwm_out[i+3]);
            if (pwm_out[i] && pwm_out[i+3]) overlap++;
         end
      end
      for (int i = 0; i < 3; i++) begin
         int h;
         h = raw_high(p, duty[i]);
         check($sformatf("R2 R3 R4 phase %0d high side P=%0d d=%0d dt=%0d", i, p, duty[i], dt),
               pc[i], side_on(h, 2 * p, dt));
         check($sformatf("R2 R3 R4 phase %0d low side P=%0d d=%0d dt=%0d", i, p, duty[i], dt),
               nc[i], side_on(2 * p - h, 2 * p, dt));
      end
      check("R3 paired outputs overlap", overlap, 0);

      car_err = 0; pos_err = 0; adc_err = 0; adc_seen = 0;
      ncrest = 0; ntrough = 0; since = -1; prev = 0;
      for (int c = 0; c < 4 * p * (s + 1); c++) begin
         @(negedge clk);
         if (c > 0) begin
            if (int'(carrier_cnt) - prev != 1 && prev - int'(carrier_cnt) != 1) car_err++;
         end
         if (int'(carrier_cnt) > p) car_err++;
         prev = int'(carrier_cnt);
         if (irq_crest) begin
            ncrest++;
            if (carrier_up || int'(carrier_cnt) != p - 1) pos_err++;
         end
         if (irq_trough) begin
            ntrough++;
            if (!carrier_up || carrier_cnt != 16'd1) pos_err++;
         end
         if (since >= 0) since++;
         if (adc_trig) begin
            if (since >= 0) begin
               adc_seen++;
               if (since != dl + 2) adc_err++;
            end
            since = -1;
         end
         if (int'(carrier_cnt) == p && carrier_up) since = 0;
      end
      check("R1 carrier steps and bounds", car_err, 0);
      check($sformatf("R6 crest pulses skip=%0d", s), ncrest, 2);
      check($sformatf("R6 trough pulses skip=%0d", s), ntrough, 2);
      check("R6 pulse position", pos_err, 0);
      check($sformatf("R7 adc delay D=%0d", dl), adc_err, 0);
      check("R7 adc pulses present", int'(adc_seen > 0), 1);
   endtask

   initial begin
      int p, dt, s, dl;
      int d[3];
      int rise, lim;
      logic last;
      void'($urandom(32'd7741));
      tick(5);
      rst_n = 1'b1;
      tick(2);
      // R10
      check("R10 reset pwm_out", int'(pwm_out), 0);
      check("R10 reset pwm_oe", int'(pwm_oe), 63);
      check("R10 reset irq/adc", int'({irq_crest, irq_trough, adc_trig}), 0);
      check("R10 reset carrier", int'(carrier_cnt), 0);
      check("R10 reset direction", int'(carrier_up), 1);

      for (int it = 0; it < 6; it++) begin
         p  = 8 + int'($urandom_range(0, 32));
         dt = int'($urandom_range(0, 5));
         s  = int'($urandom_range(0, 3));
         dl = int'($urandom_range(0, p - 1));
         for (int i = 0; i < 3; i++) d[i] = int'($urandom_range(0, p + 2));
         if (it == 0) begin d[0] = 0; d[1] = p; d[2] = p - 1; end
         if (it == 1) begin d[0] = 1; d[1] = 65535; d[2] = p / 2; end
         run_cfg(p, dt, d[0], d[1], d[2], s, dl);
      end

      // R5: duty write mid-cycle takes effect only at a turning point
      run_cfg(40, 0, 30, 30, 30, 0, 5);
      lim = 0;
      do begin @(negedge clk); lim++; end while (!irq_trough && lim < 400);
      wr(REG_DUTY_A, 10);
      rise = -1; last = pwm_out[0]; lim = 0;
      while (rise < 0 && lim < 400) begin
         @(negedge clk); lim++;
         if (pwm_out[0] && !last) rise = int'(carrier_cnt);
         last = pwm_out[0];
      end
      check_rng("R5 old duty held until turning point", rise, 30, 34);
      rise = -1; lim = 0;
      while (rise < 0 && lim < 400) begin
         @(negedge clk); lim++;
         if (pwm_out[0] && !last) rise = int'(carrier_cnt);
         last = pwm_out[0];
      end
      check_rng("R5 new duty after turning point", rise, 10, 14);

      // R8: level mode
      wr(REG_CTRL, 3);
      @(negedge clk); emerg_n = 1'b0;
      tick(4);
      check("R8 level shutdown oe", int'(pwm_oe), 0);
      check("R8 level shutdown out", int'(pwm_out), 0);
      emerg_n = 1'b1;
      tick(5);
      check("R9 shutdown latched after release", int'(pwm_oe), 0);
      wr(REG_CTRL, 7);
      check("R9 clear restores enables", int'(pwm_oe), 63);

      // R9: edge mode
      wr(REG_CTRL, 1);
      tick(3);
      emerg_n = 1'b0;
      tick(6);
      check("R9 edge shutdown oe", int'(pwm_oe), 0);
      wr(REG_CTRL, 5);
      tick(1);
      check("R9 clear refused while input low", int'(pwm_oe), 0);
      emerg_n = 1'b1;
      tick(5);
      check("R9 edge shutdown latched", int'(pwm_oe), 0);
      wr(REG_CTRL, 5);
      check("R9 edge clear restores enables", int'(pwm_oe), 63);
      tick(100);
      check("R9 outputs switching after clear", int'(pwm_out != 6'd0 || carrier_cnt != 16'd0), 1);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule